// File: doc/BRIEF.md
# Instruction Fetch Handshake Controller

This block runs the fetch side of a small serial processor. When the surrounding core signals that it is ready for its next instruction, the controller opens a cycle on a classic Wishbone-style bus and keeps it open until memory acknowledges. The instruction word is valid on the read-data lines only in the acknowledge cycle, so the controller registers it at that edge.

The same acknowledge edge also closes the bus cycle, keeps the instruction fields that the decoder and the immediate generator need, and sends a single-cycle read request to the serial register file. No intermediate state lies between these steps. The captured fields stay valid and unchanged until the next acknowledged fetch.

Top module: `ifetch_handshake`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, `bus_cyc_o` and `rf_rd_req_o` are 0 after the edge, and every captured field output is 0.
- R2: A `next_insn_i` pulse that is sampled while no bus cycle is open makes `bus_cyc_o` go high after that edge.
- R3: Once `bus_cyc_o` is high, it stays high at every edge where `bus_ack_i` is low.
- R4: An edge that samples `bus_ack_i` high while `bus_cyc_o` is high drops `bus_cyc_o` after that edge. The bus cycle therefore closes exactly one cycle after the acknowledge.
- R5: The same edge raises `rf_rd_req_o` for exactly one cycle. `rf_rd_req_o` is never high at any other time.
- R6: At that edge the outputs take these bits of `bus_rdata_i`: `opcode_o` from bits [6:0], `funct3_o` from bits [14:12], `rs1_o` from bits [19:15], `rs2_o` from bits [24:20], and `imm_raw_o` from bits [31:7].
- R7: The captured field outputs change only at an acknowledged edge.
- R8: When `bus_ack_i` is high while no bus cycle is open, it is ignored. No read request is raised and the fields keep their values.
- R9: A `next_insn_i` pulse that arrives while a bus cycle is open, including in the acknowledge cycle itself, is ignored. No further fetch follows it.
- R10: A `next_insn_i` pulse in the cycle where `rf_rd_req_o` is high is accepted. The new bus cycle opens right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| next_insn_i | input | 1 | Pulse: core is ready for another instruction |
| bus_cyc_o | output | 1 | Fetch bus cycle request |
| bus_ack_i | input | 1 | Memory acknowledge |
| bus_rdata_i | input | 32 | Instruction word, valid with the acknowledge |
| rf_rd_req_o | output | 1 | One-cycle register-file read request |
| opcode_o | output | 7 | Captured opcode field |
| funct3_o | output | 3 | Captured function field |
| rs1_o | output | 5 | Captured first source register index |
| rs2_o | output | 5 | Captured second source register index |
| imm_raw_o | output | 25 | Captured raw immediate bits |

## Verification
Two events can land in the same cycle. The first is the acknowledge that closes a fetch. The second is the core's next-instruction pulse, which can arrive in that acknowledge cycle or in the read-request cycle that follows it. The bench sets up each case on purpose and also sets it up at random, with memory latencies of zero to five cycles. A pulse that arrives together with the acknowledge must leave the bus idle afterwards. A pulse that arrives together with the read request must open a new cycle at once. A behavioural model computes the expected bus and field outputs, and the bench compares the design against it on every clock.

// File: rtl/ifetch_pkg.sv
// Package ifetch_pkg
// Shared widths and the layout of the instruction fields that are captured.
// Assumes a 32-bit instruction word in which the field positions are fixed.
package ifetch_pkg;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned N_FLD  = 5;

    // Field order: 0 opcode, 1 funct3, 2 rs1, 3 rs2, 4 raw immediate
    localparam int unsigned FLD_LSB [N_FLD] = '{0, 12, 15, 20, 7};
    localparam int unsigned FLD_W   [N_FLD] = '{7, 3, 5, 5, 25};

    // Bit offset of a field inside the flat capture vector
    function automatic int unsigned fld_off(input int unsigned idx);
        int unsigned s;
        s = 0;
        for (int unsigned k = 0; k < idx; k++) s += FLD_W[k];
        return s;
    endfunction

    localparam int unsigned FLAT_W = fld_off(N_FLD);

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/ifetch_seq.sv
// Module ifetch_seq
// Sequences one fetch: opens the bus cycle on a next pulse, holds it
// until the acknowledge arrives, then closes it and strobes the register
// file read request in the following cycle. Assumes the acknowledge is
// only meaningful while the cycle is open.
module ifetch_seq
    import ifetch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic next_i,
    input  logic ack_i,
    output logic cyc_o,
    output logic capture_o,
    output logic rreq_o
);
    fetch_state_e state_q;
    logic         done;

    // Acknowledge qualified by an open cycle
    always_comb done = (state_q == FS_WAIT) && ack_i;

    // Fetch state: idle until a pulse, waiting until the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            unique case (state_q)
                FS_IDLE: if (next_i) state_q <= FS_WAIT;
                FS_WAIT: if (ack_i)  state_q <= FS_IDLE;
                default:             state_q <= FS_IDLE;
            endcase
        end
    end

    // Single-cycle read strobe following the acknowledge edge
    always_ff @(posedge clk) begin
        if (!rst_n) rreq_o <= 1'b0;
        else        rreq_o <= done;
    end

    assign cyc_o     = (state_q == FS_WAIT);
    assign capture_o = done;
endmodule

// File: rtl/ifetch_field_reg.sv
// Module ifetch_field_reg
// One loadable field register that clears on reset.
// Assumes that load is asserted only on an acknowledged fetch edge.
module ifetch_field_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Hold the field, reload on capture
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/ifetch_handshake.sv
// Module ifetch_handshake
// Top of the fetch handshake: bus request and acknowledge, capture of the
// instruction fields, and the register-file read request. Assumes a
// classic single-beat bus in which data is valid with the acknowledge.
module ifetch_handshake
    import ifetch_pkg::*;
#(
    parameter int unsigned DATA_W = INSN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              next_insn_i,
    output logic              bus_cyc_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              rf_rd_req_o,
    output logic [FLD_W[0]-1:0] opcode_o,
    output logic [FLD_W[1]-1:0] funct3_o,
    output logic [FLD_W[2]-1:0] rs1_o,
    output logic [FLD_W[3]-1:0] rs2_o,
    output logic [FLD_W[4]-1:0] imm_raw_o
);
    logic              capture;
    logic [FLAT_W-1:0] fld_flat;

    ifetch_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_i    (next_insn_i),
        .ack_i     (bus_ack_i),
        .cyc_o     (bus_cyc_o),
        .capture_o (capture),
        .rreq_o    (rf_rd_req_o)
    );

    // One register per field, taken from its fixed slice of the word
    for (genvar g = 0; g < N_FLD; g++) begin : g_fld
        localparam int unsigned W = FLD_W[g];
        localparam int unsigned L = FLD_LSB[g];
        localparam int unsigned O = fld_off(g);
        ifetch_field_reg #(.W(W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (capture),
            .d_i    (bus_rdata_i[L+W-1:L]),
            .q_o    (fld_flat[O+W-1:O])
        );
    end

    assign opcode_o  = fld_flat[fld_off(0) +: FLD_W[0]];
    assign funct3_o  = fld_flat[fld_off(1) +: FLD_W[1]];
    assign rs1_o     = fld_flat[fld_off(2) +: FLD_W[2]];
    assign rs2_o     = fld_flat[fld_off(3) +: FLD_W[3]];
    assign imm_raw_o = fld_flat[fld_off(4) +: FLD_W[4]];
endmodule

// File: rtl/ifetch_handshake_chk.sv
// Module ifetch_handshake_chk
// Protocol properties of the fetch handshake, bound to the top module.
module ifetch_handshake_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        next_insn_i,
    input logic        bus_cyc_o,
    input logic        bus_ack_i,
    input logic [31:0] bus_rdata_i,
    input logic        rf_rd_req_o,
    input logic [6:0]  opcode_o,
    input logic [2:0]  funct3_o,
    input logic [4:0]  rs1_o,
    input logic [4:0]  rs2_o,
    input logic [24:0] imm_raw_o
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cyc_o && next_insn_i) |=> bus_cyc_o);

    p_cyc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && !bus_ack_i) |=> bus_cyc_o);

    p_cyc_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && bus_ack_i) |=> !bus_cyc_o);

    p_rreq_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && bus_ack_i) |=> rf_rd_req_o);

    p_rreq_only_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cyc_o && bus_ack_i) |=> !rf_rd_req_o);

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && bus_ack_i) |=>
            (opcode_o == $past(bus_rdata_i[6:0])) && (funct3_o == $past(bus_rdata_i[14:12]))
            && (rs1_o == $past(bus_rdata_i[19:15])) && (rs2_o == $past(bus_rdata_i[24:20]))
            && (imm_raw_o == $past(bus_rdata_i[31:7])));

    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cyc_o && bus_ack_i) |=>
            $stable(opcode_o) && $stable(funct3_o) && $stable(rs1_o)
            && $stable(rs2_o) && $stable(imm_raw_o));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_req_o |-> !bus_cyc_o || next_insn_i || $past(next_insn_i));
endmodule

bind ifetch_handshake ifetch_handshake_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_insn_i (next_insn_i),
    .bus_cyc_o   (bus_cyc_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .rf_rd_req_o (rf_rd_req_o),
    .opcode_o    (opcode_o),
    .funct3_o    (funct3_o),
    .rs1_o       (rs1_o),
    .rs2_o       (rs2_o),
    .imm_raw_o   (imm_raw_o)
);

// File: tb/ifetch_handshake_tb.sv
module ifetch_handshake_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        next_insn = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] rdata = '0;
    logic        cyc, rreq;
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [4:0]  r1, r2;
    logic [24:0] imm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .next_insn_i(next_insn), .bus_cyc_o(cyc),
        .bus_ack_i(ack), .bus_rdata_i(rdata), .rf_rd_req_o(rreq),
        .opcode_o(opc), .funct3_o(f3), .rs1_o(r1), .rs2_o(r2), .imm_raw_o(imm)
    );

    // Behavioural reference: bus open flag, strobe flag, last accepted word
    bit          m_open, m_req;
    logic [31:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_req = 0; m_word = '0;
        end else if (m_open && ack) begin
            m_open = 0; m_req = 1; m_word = rdata;
        end else begin
            m_req = 0;
            if (!m_open && next_insn) m_open = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check(cyc == m_open, "R2/R3/R4/R9/R10", "bus_cyc", cyc, m_open);
            check(rreq == m_req, "R5/R8", "rf_rd_req", rreq, m_req);
            check(opc == m_word[6:0], "R6/R7/R8", "opcode", opc, m_word[6:0]);
            check(f3 == m_word[14:12], "R6/R7", "funct3", f3, m_word[14:12]);
            check(r1 == m_word[19:15], "R6/R7", "rs1", r1, m_word[19:15]);
            check(r2 == m_word[24:20], "R6/R7", "rs2", r2, m_word[24:20]);
            check(imm == m_word[31:7], "R6/R7", "imm", imm, m_word[31:7]);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One fetch; caller states whether a start pulse is still needed
    task automatic run_fetch(input int dly, input logic [31:0] w, input bit nx_ack,
                             input bit nx_after, input bit need_start);
        if (need_start) begin
            next_insn = 1'b1; @(negedge clk); next_insn = 1'b0;
        end
        check(cyc == 1'b1, "R2", "cyc open", cyc, 1);
        for (int i = 0; i < dly; i++) begin
            ack = 1'b0; next_insn = 1'($urandom % 2); rdata = $urandom;
            @(negedge clk);
            check(cyc == 1'b1, "R3", "cyc held", cyc, 1);
        end
        ack = 1'b1; rdata = w; next_insn = nx_ack;
        @(negedge clk);
        check(cyc == 1'b0, "R4", "cyc one cycle after ack", cyc, 0);
        check(rreq == 1'b1, "R5", "strobe after ack", rreq, 1);
        check({imm, r2, r1, f3, opc} == {w[31:7], w[24:20], w[19:15], w[14:12], w[6:0]},
              "R6", "fields", {imm, r2, r1, f3, opc}, {w[31:7], w[24:20], w[19:15], w[14:12], w[6:0]});
        ack = 1'b0; next_insn = nx_after; rdata = $urandom;
        @(negedge clk);
        next_insn = 1'b0;
        check(rreq == 1'b0, "R5", "strobe one cycle", rreq, 0);
        if (nx_after) check(cyc == 1'b1, "R10", "pulse with strobe", cyc, 1);
        else          check(cyc == 1'b0, "R9", "pulse with ack ignored", cyc, 0);
    endtask

    initial begin
        bit chained;
        @(negedge clk); @(negedge clk);
        check(cyc == 0 && rreq == 0 && opc == 0 && imm == 0, "R1", "reset state",
              {cyc, rreq, opc}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Stray acknowledge while idle
        ack = 1'b1; rdata = 32'hDEAD_BEEF; @(negedge clk); ack = 1'b0;
        check(rreq == 0 && opc == 0, "R8", "stray ack", {rreq, opc}, 0);

        // Directed: zero latency, pulse in ack cycle, then pulse with strobe
        run_fetch(0, 32'h00A3_0F33, 1'b1, 1'b0, 1'b1);
        run_fetch(2, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);
        run_fetch(1, 32'h1234_5678, 1'b0, 1'b0, 1'b0);

        // Random latencies and coincident pulses
        chained = 0;
        for (int n = 0; n < 60; n++) begin
            bit na;
            na = (n == 59) ? 1'b0 : 1'($urandom % 2);
            run_fetch(int'($urandom % 6), $urandom, 1'($urandom % 2), na, !chained);
            chained = na;
            if (!chained) begin
                for (int k = 0; k < int'($urandom % 3); k++) begin
                    ack = 1'($urandom % 2); rdata = $urandom; @(negedge clk);
                    ack = 1'b0;
                    check(rreq == 1'b0, "R8", "idle ack ignored", rreq, 0);
                end
            end
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule